// File: doc/BRIEF.md
# Illegal Instruction Trap Controller

This block sits beside the decode stage of a 32-bit in-order integer pipeline. It inspects every decoded instruction word against the base integer encoding rules and raises a combinational illegal flag when the word is malformed. The checks cover unknown opcodes, funct3 values with no defined operation, and nonzero funct7 bits where the encoding requires zeros. An illegal instruction normally starts a synchronous machine-mode exception. The block does not start one when either of the two following pipeline stages is flushing in the same cycle, because the faulting instruction would be discarded anyway.

When the exception is taken, a one-cycle registered pulse appears on the next rising edge. That pulse kills the faulting instruction, which becomes a NOP, and redirects fetch to the trap vector. In the same pulse the block writes the cause code 2, the faulting PC and the raw instruction word into the cause, exception-PC and trap-value registers. It also saves the interrupt enable into its "previous" slot and clears the enable. A return-from-trap indication restores the enable from the saved copy, sets the saved copy to one and redirects fetch to the exception PC supplied by the CSR file.

Top module: `illegal_trap_ctrl`

## Requirements
- R1: With `instrValid` high, `illegalFlag` is high in the same cycle for an OP word (opcode 0110011) whose funct7 is neither 0000000 nor 0100000. It is also high when funct7 is 0100000 but funct3 is not 000 or 101. For OP-IMM (opcode 0010011), funct3 001 needs funct7 0000000, and funct3 101 needs 0000000 or 0100000; any other funct7 is illegal (e.g. 0xFFF79793).
- R2: `illegalFlag` is high for a funct3 with no operation. The defined values are: LOAD (0000011) 000/001/010/100/101; STORE (0100011) 000/001/010; JALR (1100111) 000; BRANCH (1100011) any value except 010/011; MISC-MEM (0001111) 000; SYSTEM (1110011) any value except 100.
- R3: `illegalFlag` is high for any opcode other than 0110111, 0010111, 1101111, 1100111, 1100011, 0000011, 0100011, 0010011, 0110011, 0001111 and 1110011. This includes the all-zero and all-ones words.
- R4: `illegalFlag` stays low for well-formed words of every accepted opcode.
- R5: An illegal word that coincides with `flushEx` or `flushMem` produces no trap pulse on the next edge.
- R6: One edge after a taken trap, `killInstr` and `redirectValid` are high for one cycle, with `redirectPc` equal to the sampled `mtvecIn`.
- R7: In the same pulse, `mcauseWe`, `mepcWe` and `mtvalWe` are high, with `mcauseData` = 0x00000002, `mepcData` = the faulting `instrPc` and `mtvalData` = the faulting `instrWord`.
- R8: In the same pulse, `mstatusWe` is high, `mieData` is 0 and `mpieData` equals the sampled `mieIn`.
- R9: One edge after `mretIn` with no trap taken, `mstatusWe` and `redirectValid` pulse. In that pulse `mieData` equals the saved previous-enable bit, `mpieData` is 1 and `redirectPc` equals the sampled `mepcIn`. The trap CSR strobes stay low.
- R10: Synchronous active-high `rst` drives every strobe low and clears the saved previous-enable bit. An `mretIn` right after reset therefore yields `mieData` = 0.
- R11: If a trap is taken in the same cycle as `mretIn`, the trap pulse is produced and the return is ignored.
- R12: With `instrValid` low, `illegalFlag` is low and no trap is taken, whatever `instrWord` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instrValid | input | 1 | Decode holds a valid instruction |
| instrWord | input | 32 | Decoded instruction word |
| instrPc | input | 32 | PC of the decoded instruction |
| flushEx | input | 1 | Next stage is flushing |
| flushMem | input | 1 | Stage after that is flushing |
| mieIn | input | 1 | Current machine interrupt enable |
| mtvecIn | input | 32 | Trap vector address |
| mepcIn | input | 32 | Current exception PC, for return |
| mretIn | input | 1 | Return-from-trap executing |
| illegalFlag | output | 1 | Combinational illegal-encoding flag |
| killInstr | output | 1 | Replace faulting instruction by NOP |
| redirectValid | output | 1 | Fetch redirect strobe |
| redirectPc | output | 32 | Fetch redirect target |
| mcauseWe | output | 1 | Cause register write strobe |
| mcauseData | output | 32 | Cause write value |
| mepcWe | output | 1 | Exception-PC write strobe |
| mepcData | output | 32 | Exception-PC write value |
| mtvalWe | output | 1 | Trap-value write strobe |
| mtvalData | output | 32 | Trap-value write value |
| mstatusWe | output | 1 | Enable/previous-enable write strobe |
| mieData | output | 1 | New interrupt enable |
| mpieData | output | 1 | New previous interrupt enable |

## Verification
The legality check is exercised with one legal and at least one illegal word per accepted opcode. Each illegal word is chosen so that a single field decides the outcome: funct7 on shifts and register ops, funct3 on loads, stores, jumps, branches, fences and system words, and the opcode alone for reserved, all-zero and all-ones words. Trap entry is tried with the enable both set and clear, which shows that the saved previous-enable value really is sampled. Directed cases then separate a flush from either younger stage, a return before any trap (saved bit from reset), a return after a trap, a trap that collides with a return, and a valid-low cycle carrying an illegal word.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned XLEN = 32;
  localparam logic [XLEN-1:0] CAUSE_ILLEGAL = 32'h0000_0002;

  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_FENCE  = 7'b0001111;
  localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

  typedef struct packed {
    logic takeTrap;
    logic doReturn;
  } trapStrobes_t;
endpackage

// File: rtl/trap_legality.sv
module trap_legality
  import trap_pkg::*;
#(
  parameter bit ALLOW_FENCE_I = 1'b0
) (
  input  logic [31:0] word,
  output logic        isIllegal
);
  logic [6:0] opcode;
  logic [2:0] funct3;
  logic [6:0] funct7;
  logic       fenceOk;

  assign opcode = word[6:0];
  assign funct3 = word[14:12];
  assign funct7 = word[31:25];

  generate
    if (ALLOW_FENCE_I) begin : g_fencei
      assign fenceOk = (funct3 == 3'b000) || (funct3 == 3'b001);
    end else begin : g_fence_only
      assign fenceOk = (funct3 == 3'b000);
    end
  endgenerate

  always_comb begin
    isIllegal = 1'b0;
    unique case (opcode)
      OPC_LUI, OPC_AUIPC, OPC_JAL: isIllegal = 1'b0;
      OPC_JALR:   isIllegal = (funct3 != 3'b000);
      OPC_BRANCH: isIllegal = (funct3 == 3'b010) || (funct3 == 3'b011);
      OPC_LOAD:   isIllegal = (funct3 == 3'b011) || (funct3 == 3'b110) || (funct3 == 3'b111);
      OPC_STORE:  isIllegal = (funct3[2] == 1'b1) || (funct3 == 3'b011);
      OPC_OPIMM: begin
        if (funct3 == 3'b001)      isIllegal = (funct7 != 7'b0000000);
        else if (funct3 == 3'b101) isIllegal = (funct7 != 7'b0000000) && (funct7 != 7'b0100000);
        else                       isIllegal = 1'b0;
      end
      OPC_OP: begin
        if (funct7 == 7'b0000000)      isIllegal = 1'b0;
        else if (funct7 == 7'b0100000) isIllegal = (funct3 != 3'b000) && (funct3 != 3'b101);
        else                           isIllegal = 1'b1;
      end
      OPC_FENCE:  isIllegal = !fenceOk;
      OPC_SYSTEM: isIllegal = (funct3 == 3'b100);
      default:    isIllegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/trap_control.sv
module trap_control
  import trap_pkg::*;
(
  input  logic         preIllegal,
  input  logic         flushEx,
  input  logic         flushMem,
  input  logic         mretIn,
  output trapStrobes_t strobes
);
  always_comb begin
    strobes.takeTrap = preIllegal && !(flushEx || flushMem);
    strobes.doReturn = mretIn && !strobes.takeTrap;
  end
endmodule

// File: rtl/trap_datapath.sv
module trap_datapath
  import trap_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  trapStrobes_t    strobes,
  input  logic [XLEN-1:0] instrWord,
  input  logic [XLEN-1:0] instrPc,
  input  logic            mieIn,
  input  logic [XLEN-1:0] mtvecIn,
  input  logic [XLEN-1:0] mepcIn,
  output logic            killInstr,
  output logic            redirectValid,
  output logic [XLEN-1:0] redirectPc,
  output logic            mcauseWe,
  output logic [XLEN-1:0] mcauseData,
  output logic            mepcWe,
  output logic [XLEN-1:0] mepcData,
  output logic            mtvalWe,
  output logic [XLEN-1:0] mtvalData,
  output logic            mstatusWe,
  output logic            mieData,
  output logic            mpieData
);
  logic savedMpie;

  always_ff @(posedge clk) begin
    if (rst) begin
      killInstr     <= 1'b0;
      redirectValid <= 1'b0;
      redirectPc    <= '0;
      mcauseWe      <= 1'b0;
      mcauseData    <= '0;
      mepcWe        <= 1'b0;
      mepcData      <= '0;
      mtvalWe       <= 1'b0;
      mtvalData     <= '0;
      mstatusWe     <= 1'b0;
      mieData       <= 1'b0;
      mpieData      <= 1'b0;
      savedMpie     <= 1'b0;
    end else begin
      killInstr     <= strobes.takeTrap;
      mcauseWe      <= strobes.takeTrap;
      mepcWe        <= strobes.takeTrap;
      mtvalWe       <= strobes.takeTrap;
      redirectValid <= strobes.takeTrap || strobes.doReturn;
      mstatusWe     <= strobes.takeTrap || strobes.doReturn;
      if (strobes.takeTrap) begin
        redirectPc <= mtvecIn;
        mcauseData <= CAUSE_ILLEGAL;
        mepcData   <= instrPc;
        mtvalData  <= instrWord;
        mieData    <= 1'b0;
        mpieData   <= mieIn;
        savedMpie  <= mieIn;
      end else if (strobes.doReturn) begin
        redirectPc <= mepcIn;
        mieData    <= savedMpie;
        mpieData   <= 1'b1;
        savedMpie  <= 1'b1;
      end
    end
  end

  // R8: entry always clears the enable it writes
  p_entry_clears_mie_r8: assert property (@(posedge clk) disable iff (rst)
    mcauseWe |-> (mstatusWe && !mieData));
  // R9: return writes a set previous-enable and touches no trap CSR
  p_return_sets_mpie_r9: assert property (@(posedge clk) disable iff (rst)
    (mstatusWe && !mcauseWe) |-> (mpieData && !mepcWe && !mtvalWe));
endmodule

// File: rtl/illegal_trap_ctrl.sv
module illegal_trap_ctrl
  import trap_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        instrValid,
  input  logic [31:0] instrWord,
  input  logic [31:0] instrPc,
  input  logic        flushEx,
  input  logic        flushMem,
  input  logic        mieIn,
  input  logic [31:0] mtvecIn,
  input  logic [31:0] mepcIn,
  input  logic        mretIn,
  output logic        illegalFlag,
  output logic        killInstr,
  output logic        redirectValid,
  output logic [31:0] redirectPc,
  output logic        mcauseWe,
  output logic [31:0] mcauseData,
  output logic        mepcWe,
  output logic [31:0] mepcData,
  output logic        mtvalWe,
  output logic [31:0] mtvalData,
  output logic        mstatusWe,
  output logic        mieData,
  output logic        mpieData
);
  logic         wordBad;
  trapStrobes_t strobes;

  trap_legality #(.ALLOW_FENCE_I(1'b0)) u_legal (
    .word      (instrWord),
    .isIllegal (wordBad)
  );

  assign illegalFlag = instrValid && wordBad;

  trap_control u_ctrl (
    .preIllegal (illegalFlag),
    .flushEx    (flushEx),
    .flushMem   (flushMem),
    .mretIn     (mretIn),
    .strobes    (strobes)
  );

  trap_datapath u_dp (
    .clk           (clk),
    .rst           (rst),
    .strobes       (strobes),
    .instrWord     (instrWord),
    .instrPc       (instrPc),
    .mieIn         (mieIn),
    .mtvecIn       (mtvecIn),
    .mepcIn        (mepcIn),
    .killInstr     (killInstr),
    .redirectValid (redirectValid),
    .redirectPc    (redirectPc),
    .mcauseWe      (mcauseWe),
    .mcauseData    (mcauseData),
    .mepcWe        (mepcWe),
    .mepcData      (mepcData),
    .mtvalWe       (mtvalWe),
    .mtvalData     (mtvalData),
    .mstatusWe     (mstatusWe),
    .mieData       (mieData),
    .mpieData      (mpieData)
  );

  p_flush_cancels_r5: assert property (@(posedge clk) disable iff (rst)
    (illegalFlag && (flushEx || flushMem) && !mretIn) |=> !mcauseWe && !redirectValid);
  p_redirect_vector_r6: assert property (@(posedge clk) disable iff (rst)
    (illegalFlag && !flushEx && !flushMem) |=>
      (killInstr && redirectValid && redirectPc == $past(mtvecIn)));
  p_capture_word_r7: assert property (@(posedge clk) disable iff (rst)
    (illegalFlag && !flushEx && !flushMem) |=>
      (mtvalData == $past(instrWord) && mepcData == $past(instrPc) && mcauseData == 32'h2));
  p_return_target_r9: assert property (@(posedge clk) disable iff (rst)
    (mretIn && !(illegalFlag && !flushEx && !flushMem)) |=>
      (redirectValid && redirectPc == $past(mepcIn) && !killInstr));
  p_valid_gate_r12: assert property (@(posedge clk) disable iff (rst)
    !instrValid |-> !illegalFlag);
endmodule

// File: tb/sim_illegal_trap_ctrl.sv
`timescale 1ns/1ps
module sim_illegal_trap_ctrl;
  logic clk = 1'b0;
  logic rst, instrValid, flushEx, flushMem, mieIn, mretIn;
  logic [31:0] instrWord, instrPc, mtvecIn, mepcIn;
  logic illegalFlag, killInstr, redirectValid, mcauseWe, mepcWe, mtvalWe, mstatusWe, mieData, mpieData;
  logic [31:0] redirectPc, mcauseData, mepcData, mtvalData;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  illegal_trap_ctrl u0 (.*);

  localparam int NVEC = 34;
  // {word, expected illegal}
  localparam logic [32:0] VEC [NVEC] = '{
    {32'hFFF79793, 1'b1}, {32'h00179793, 1'b0}, {32'h40005013, 1'b0}, {32'h20005013, 1'b1},
    {32'h00000033, 1'b0}, {32'h40000033, 1'b0}, {32'h40007033, 1'b1}, {32'h02000033, 1'b1},
    {32'hFEF42423, 1'b0}, {32'h00007023, 1'b1}, {32'h00003023, 1'b1}, {32'hFEC42703, 1'b0},
    {32'h00003003, 1'b1}, {32'h00005003, 1'b0}, {32'h00008067, 1'b0}, {32'h00001067, 1'b1},
    {32'h00000063, 1'b0}, {32'h00002063, 1'b1}, {32'h00007063, 1'b0}, {32'h000000B7, 1'b0},
    {32'h00000017, 1'b0}, {32'h0000006F, 1'b0}, {32'h0000000F, 1'b0}, {32'h0000200F, 1'b1},
    {32'h00000073, 1'b0}, {32'h00004073, 1'b1}, {32'h30529073, 1'b0}, {32'h00000000, 1'b1},
    {32'hFFFFFFFF, 1'b1}, {32'h0000202F, 1'b1}, {32'h00000001, 1'b1}, {32'h00004013, 1'b0},
    {32'hFE001033, 1'b1}, {32'h00001003, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    instrValid = 1'b0; flushEx = 1'b0; flushMem = 1'b0; mretIn = 1'b0;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; idle(); instrWord = '0; instrPc = '0; mieIn = 1'b1;
    mtvecIn = 32'h100; mepcIn = 32'h2000;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!redirectValid && !mcauseWe && !mstatusWe && !killInstr, "R10 reset strobes",
          {28'h0, redirectValid, mcauseWe, mstatusWe, killInstr}, 32'h0);
    rst = 1'b0;
    // R10: return straight after reset restores enable from cleared saved bit
    mretIn = 1'b1;
    @(negedge clk); idle();
    check(mstatusWe && mieData == 1'b0 && mpieData == 1'b1, "R10 saved bit cleared",
          {30'h0, mieData, mpieData}, 32'h1);
    @(negedge clk);

    // R1 R2 R3 R4 R6 R7 R8: table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] w; logic ill; logic [31:0] pc;
      w = VEC[i][32:1]; ill = VEC[i][0]; pc = 32'h1000 + 32'(i) * 4;
      instrValid = 1'b1; instrWord = w; instrPc = pc; mieIn = i[0];
      #1;
      check(illegalFlag == ill, ill ? "R1/R2/R3 illegal word" : "R4 legal word", w, {31'h0, ill});
      @(negedge clk); idle();
      check(redirectValid == ill && killInstr == ill && mcauseWe == ill, "R6 trap pulse",
            {29'h0, redirectValid, killInstr, mcauseWe}, {29'h0, ill, ill, ill});
      if (ill) begin
        check(redirectPc == 32'h100, "R6 vector", redirectPc, 32'h100);
        check(mcauseData == 32'h2 && mepcWe && mtvalWe, "R7 cause", mcauseData, 32'h2);
        check(mepcData == pc, "R7 epc", mepcData, pc);
        check(mtvalData == w, "R7 tval", mtvalData, w);
        check(mstatusWe && !mieData && mpieData == i[0], "R8 enable save",
              {30'h0, mieData, mpieData}, {31'h0, i[0]});
      end
      @(negedge clk);
      check(!redirectValid && !mcauseWe, "R6 single pulse", {31'h0, redirectValid}, 32'h0);
    end

    // R5: flush from either younger stage
    instrValid = 1'b1; instrWord = 32'hFFF79793; flushEx = 1'b1;
    @(negedge clk); idle();
    check(!mcauseWe && !redirectValid && !killInstr, "R5 flushEx", {31'h0, mcauseWe}, 32'h0);
    instrValid = 1'b1; flushMem = 1'b1;
    @(negedge clk); idle();
    check(!mcauseWe && !redirectValid && !killInstr, "R5 flushMem", {31'h0, mcauseWe}, 32'h0);

    // R8 R9: trap with enable set, then return restores it
    instrValid = 1'b1; instrWord = 32'h0; instrPc = 32'h3000; mieIn = 1'b1;
    @(negedge clk); idle();
    check(mpieData == 1'b1 && mieData == 1'b0, "R8 save set", {30'h0, mieData, mpieData}, 32'h1);
    mretIn = 1'b1; mepcIn = 32'h3004; mieIn = 1'b0;
    @(negedge clk); idle();
    check(redirectValid && redirectPc == 32'h3004, "R9 return target", redirectPc, 32'h3004);
    check(mstatusWe && mieData && mpieData && !mcauseWe && !mepcWe && !mtvalWe, "R9 restore",
          {29'h0, mieData, mpieData, mcauseWe}, 32'h6);

    // R11: trap collides with return
    instrValid = 1'b1; instrWord = 32'hFFFFFFFF; instrPc = 32'h4000; mretIn = 1'b1; mieIn = 1'b0;
    @(negedge clk); idle();
    check(mcauseWe && redirectPc == 32'h100 && !mieData && !mpieData, "R11 trap wins", redirectPc, 32'h100);
    mretIn = 1'b1;
    @(negedge clk); idle();
    check(mieData == 1'b0, "R11 return ignored earlier", {31'h0, mieData}, 32'h0);

    // R12: invalid slot carries illegal word
    instrValid = 1'b0; instrWord = 32'hFFF79793;
    #1;
    check(!illegalFlag, "R12 flag gated", {31'h0, illegalFlag}, 32'h0);
    @(negedge clk);
    check(!mcauseWe && !redirectValid, "R12 no trap", {31'h0, mcauseWe}, 32'h0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule